// File: doc/BRIEF.md
# Halfword-Aligned Instruction Fetcher

This block owns the program counter of a small core and pulls instruction words from a 32-bit instruction memory. The memory port is a request/response pair: one word-aligned read request is accepted through a valid/ready handshake, and its data returns some cycles later on a response strobe. Instructions may be 16 or 32 bits long and may begin at any even address. The block therefore reassembles them, including a 32-bit instruction whose halves sit in two consecutive memory words. It hands each instruction to a decoder through a registered valid/ready output, together with the PC it was fetched from and a flag that says whether it is 32 bits long.

Branch, jump and trap logic steer the fetcher with a one-cycle redirect strobe and a target address. A redirect discards everything gathered on the old path: the parked halfword, the buffered word, the instruction waiting at the output and any read still in flight. Fetching then restarts at the target.

Top module: `hw_fetch_unit`

## Requirements
- R1: After reset no instruction is presented, and the first memory request reads the word at the reset vector parameter `RESET_VEC`.
- R2: An instruction is 16 bits long when bits [1:0] of its first halfword differ from 2'b11 and 32 bits long otherwise. `inst_is32` reports this length. A 16-bit instruction is presented in `inst_data[15:0]` with `inst_data[31:16]` zero.
- R3: Instructions are presented in address order. The PC advances by 2 after a 16-bit instruction and by 4 after a 32-bit one.
- R4: A 32-bit instruction starting at an address with bit 1 set is presented only once the following word has arrived. Its low half is the upper halfword of the first word and its high half is the lower halfword of the next word.
- R5: After a redirect, the next instruction accepted carries the target PC. No instruction from the old path is presented. This covers the one waiting at the output and any built from a memory response that was requested before the redirect. An instruction presented in the redirect cycle itself is not taken by the decoder.
- R6: When a redirect and a sequential advance or handshake fall in the same cycle, the redirect decides the next PC.
- R7: Bit 0 of a redirect target is cleared, so fetching restarts at the even address below it.
- R8: While an instruction is presented and not accepted, and no redirect occurs, the output keeps its instruction, PC and length unchanged.
- R9: Memory requests carry word-aligned addresses, and at most one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_valid | input | 1 | One-cycle strobe that changes the fetch path |
| redirect_target | input | AW | New byte address; bit 0 is ignored |
| mem_req_valid | output | 1 | Read request to instruction memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Word-aligned byte address of the read |
| mem_resp_valid | input | 1 | Read data is returned this cycle |
| mem_resp_data | input | 32 | Returned instruction word |
| inst_valid | output | 1 | An instruction is presented |
| inst_ready | input | 1 | Decoder takes the presented instruction |
| inst_data | output | 32 | Instruction bits; 16-bit ones are zero-extended |
| inst_pc | output | AW | Address of the presented instruction |
| inst_is32 | output | 1 | High for a 32-bit instruction |

## Verification
A redirect can land in the same cycle as a sequential step. That step may be a handshake at the output, the completion of a split instruction, or the return of a read issued on the old path. The bench provokes these collisions in a phase where redirects arrive about every fourth cycle, while `inst_ready` and the memory latency vary at random. Every accepted instruction is compared with a reference computed from the same address-hashed memory contents. Any step that outlives the redirect therefore appears as a wrong PC or wrong bits on the first instruction after the target.

// File: rtl/hwfetch_pkg.sv
package hwfetch_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // what the aligner does with the word it holds in a given cycle
  typedef enum logic [2:0] {
    STEP_IDLE,
    STEP_SHORT,   // emit a 16-bit instruction
    STEP_FULL,    // emit a 32-bit instruction lying inside one word
    STEP_PARK,    // keep upper halfword, wait for next word
    STEP_JOIN     // emit parked halfword joined with new word
  } step_e;

  function automatic logic is_short(input logic [HALF_W-1:0] h);
    return h[1:0] != 2'b11;
  endfunction

endpackage

// File: rtl/hwfetch_req_ctrl.sv
module hwfetch_req_ctrl #(
  parameter int          AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redirect_valid,
  input  logic [AW-3:0] target_word,
  input  logic          need_word,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_resp_valid,
  output logic          word_valid
);

  localparam int WAW = AW - 2;

  logic [WAW-1:0] next_word_q;
  logic           busy_q;    // one read outstanding
  logic           stale_q;   // outstanding read belongs to an old path

  assign mem_req_valid = need_word & ~busy_q & ~redirect_valid;
  assign mem_req_addr  = {next_word_q, 2'b00};
  assign word_valid    = mem_resp_valid & busy_q & ~stale_q & ~redirect_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_word_q <= RESET_VEC[AW-1:2];
      busy_q      <= 1'b0;
      stale_q     <= 1'b0;
    end else if (redirect_valid) begin
      next_word_q <= target_word;
      busy_q      <= busy_q & ~mem_resp_valid;
      stale_q     <= busy_q & ~mem_resp_valid;
    end else begin
      if (mem_resp_valid && busy_q) begin
        busy_q  <= 1'b0;
        stale_q <= 1'b0;
        if (!stale_q) next_word_q <= next_word_q + WAW'(1);
      end
      if (mem_req_valid && mem_req_ready) busy_q <= 1'b1;
    end
  end

endmodule

// File: rtl/hwfetch_aligner.sv
module hwfetch_aligner
  import hwfetch_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect_valid,
  input  logic [AW-2:0]     target_half,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              need_word,
  output logic              inst_valid,
  input  logic              inst_ready,
  output logic [WORD_W-1:0] inst_data,
  output logic [AW-1:0]     inst_pc,
  output logic              inst_is32
);

  logic [AW-1:0]     pc_q;
  logic [WORD_W-1:0] word_q;
  logic              word_ok_q;
  logic [HALF_W-1:0] park_q;
  logic              park_ok_q;
  logic              out_ok_q;
  logic [WORD_W-1:0] out_data_q;
  logic [AW-1:0]     out_pc_q;
  logic              out_is32_q;

  logic              slot_free;
  logic [HALF_W-1:0] cur_half;
  step_e             step;

  assign slot_free = ~out_ok_q | inst_ready;
  assign cur_half  = pc_q[1] ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];
  assign need_word = ~word_ok_q;

  always_comb begin
    step = STEP_IDLE;
    if (word_ok_q) begin
      if (park_ok_q) begin
        if (slot_free) step = STEP_JOIN;
      end else if (!is_short(cur_half) && pc_q[1]) begin
        step = STEP_PARK;
      end else if (slot_free) begin
        step = is_short(cur_half) ? STEP_SHORT : STEP_FULL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= {RESET_VEC[AW-1:1], 1'b0};
      word_q     <= '0;
      word_ok_q  <= 1'b0;
      park_q     <= '0;
      park_ok_q  <= 1'b0;
      out_ok_q   <= 1'b0;
      out_data_q <= '0;
      out_pc_q   <= '0;
      out_is32_q <= 1'b0;
    end else if (redirect_valid) begin
      pc_q      <= {target_half, 1'b0};
      word_ok_q <= 1'b0;
      park_ok_q <= 1'b0;
      out_ok_q  <= 1'b0;
    end else begin
      if (inst_ready) out_ok_q <= 1'b0;
      if (word_valid) begin
        word_q    <= word_data;
        word_ok_q <= 1'b1;
      end
      case (step)
        STEP_SHORT: begin
          out_ok_q   <= 1'b1;
          out_data_q <= {{HALF_W{1'b0}}, cur_half};
          out_pc_q   <= pc_q;
          out_is32_q <= 1'b0;
          pc_q       <= pc_q + AW'(2);
          if (pc_q[1]) word_ok_q <= 1'b0;
        end
        STEP_FULL: begin
          out_ok_q   <= 1'b1;
          out_data_q <= word_q;
          out_pc_q   <= pc_q;
          out_is32_q <= 1'b1;
          pc_q       <= pc_q + AW'(4);
          word_ok_q  <= 1'b0;
        end
        STEP_PARK: begin
          park_q    <= word_q[WORD_W-1:HALF_W];
          park_ok_q <= 1'b1;
          word_ok_q <= 1'b0;
        end
        STEP_JOIN: begin
          out_ok_q   <= 1'b1;
          out_data_q <= {word_q[HALF_W-1:0], park_q};
          out_pc_q   <= pc_q;
          out_is32_q <= 1'b1;
          pc_q       <= pc_q + AW'(4);
          park_ok_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign inst_valid = out_ok_q;
  assign inst_data  = out_data_q;
  assign inst_pc    = out_pc_q;
  assign inst_is32  = out_is32_q;

endmodule

// File: rtl/hw_fetch_unit.sv
module hw_fetch_unit #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = AW'(32'h0000_1000)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_target,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_resp_valid,
  input  logic [31:0]   mem_resp_data,
  output logic          inst_valid,
  input  logic          inst_ready,
  output logic [31:0]   inst_data,
  output logic [AW-1:0] inst_pc,
  output logic          inst_is32
);

  logic need_word;
  logic word_valid;

  hwfetch_req_ctrl #(.AW(AW), .RESET_VEC(RESET_VEC)) u_req (
    .clk            (clk),
    .rst            (rst),
    .redirect_valid (redirect_valid),
    .target_word    (redirect_target[AW-1:2]),
    .need_word      (need_word),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_resp_valid (mem_resp_valid),
    .word_valid     (word_valid)
  );

  hwfetch_aligner #(.AW(AW), .RESET_VEC(RESET_VEC)) u_align (
    .clk            (clk),
    .rst            (rst),
    .redirect_valid (redirect_valid),
    .target_half    (redirect_target[AW-1:1]),
    .word_valid     (word_valid),
    .word_data      (mem_resp_data),
    .need_word      (need_word),
    .inst_valid     (inst_valid),
    .inst_ready     (inst_ready),
    .inst_data      (inst_data),
    .inst_pc        (inst_pc),
    .inst_is32      (inst_is32)
  );

endmodule

// File: rtl/hwfetch_checker.sv
module hwfetch_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          redirect_valid,
  input logic          inst_valid,
  input logic          inst_ready,
  input logic [31:0]   inst_data,
  input logic [AW-1:0] inst_pc,
  input logic          inst_is32,
  input logic          mem_req_valid,
  input logic [AW-1:0] mem_req_addr
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !inst_valid); // R1

  AST_LENGTH_FLAG: assert property (@(posedge clk) disable iff (rst)
    inst_valid |-> (inst_is32 == (inst_data[1:0] == 2'b11))); // R2

  AST_SHORT_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (inst_valid && !inst_is32) |-> (inst_data[31:16] == 16'h0)); // R2

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !inst_valid); // R5

  AST_EVEN_PC: assert property (@(posedge clk) disable iff (rst)
    inst_valid |-> !inst_pc[0]); // R7

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inst_valid && !inst_ready && !redirect_valid) |=>
      (inst_valid && $stable(inst_data) && $stable(inst_pc) && $stable(inst_is32))); // R8

  AST_REQ_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R9

endmodule

bind hw_fetch_unit hwfetch_checker #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .redirect_valid (redirect_valid),
  .inst_valid     (inst_valid),
  .inst_ready     (inst_ready),
  .inst_data      (inst_data),
  .inst_pc        (inst_pc),
  .inst_is32      (inst_is32),
  .mem_req_valid  (mem_req_valid),
  .mem_req_addr   (mem_req_addr)
);

// File: tb/tb_hw_fetch_unit.sv
module tb_hw_fetch_unit;

  localparam int          AW = 32;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_target = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_resp_valid = 1'b0;
  logic [31:0]   mem_resp_data = '0;
  logic          inst_valid;
  logic          inst_ready = 1'b0;
  logic [31:0]   inst_data;
  logic [AW-1:0] inst_pc;
  logic          inst_is32;

  hw_fetch_unit #(.AW(AW), .RESET_VEC(RV)) dut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // memory model state
  bit          mem_busy = 0;
  int          mem_lat  = 0;
  logic [31:0] mem_addr = '0;

  // reference stream state
  logic [31:0] exp_pc = RV;
  string       next_tag = "R1";
  bit          hold_chk = 0;
  logic [64:0] hold_val = '0;
  int          idle = 0;
  bit          hung = 0;

  function automatic logic [15:0] half_at(input logic [31:0] a);
    logic [31:0] x;
    logic [15:0] h;
    x = (a & 32'hFFFF_FFFE) * 32'h9E37_79B1 ^ 32'h5BD1_E995;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B_3C6D;
    x = x ^ (x >> 12);
    h = x[15:0];
    if (x[20]) h[1:0] = 2'b11;
    return h;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {half_at({a[31:2], 2'b10}), half_at({a[31:2], 2'b00})};
  endfunction

  // {is32, data}
  function automatic logic [32:0] ref_instr(input logic [31:0] pc);
    logic [15:0] h0;
    h0 = half_at(pc);
    if (h0[1:0] != 2'b11) return {1'b0, 16'h0, h0};
    return {1'b1, half_at(pc + 32'd2), h0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [64:0] act,
                       input logic [64:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle, entered at the falling edge
  task automatic step(input bit force_redir, input logic [31:0] force_tgt, input int rate);
    bit          resp_now, redir;
    logic [31:0] tgt;
    logic [32:0] e;
    string       tag;
    resp_now = mem_busy && (mem_lat == 0);
    mem_resp_valid = resp_now;
    mem_resp_data  = resp_now ? word_at(mem_addr) : $urandom;
    redir = force_redir || (($urandom % rate) == 0);
    tgt   = force_redir ? force_tgt : RV + ($urandom % 2048);
    redirect_valid  = redir;
    redirect_target = tgt;
    inst_ready    = ($urandom % 4) != 0;
    mem_req_ready = ($urandom % 10) < 7;
    if (resp_now) mem_busy = 0;
    else if (mem_busy) mem_lat--;
    #1;
    if (hold_chk)  // R8
      check(inst_valid && {inst_is32, inst_pc, inst_data} == hold_val, "R8",
            {inst_is32, inst_pc, inst_data}, hold_val);
    hold_chk = inst_valid && !inst_ready && !redir;
    hold_val = {inst_is32, inst_pc, inst_data};
    idle++;
    if (inst_valid && inst_ready && !redir) begin
      e = ref_instr(exp_pc);
      if (next_tag != "") tag = next_tag;
      else if (!e[32]) tag = "R2";
      else if (exp_pc[1]) tag = "R4";
      else tag = "R3";
      check({inst_is32, inst_pc, inst_data} == {e[32], exp_pc, e[31:0]}, tag,
            {inst_is32, inst_pc, inst_data}, {e[32], exp_pc, e[31:0]});
      exp_pc   = exp_pc + (e[32] ? 32'd4 : 32'd2);
      next_tag = "";
      idle     = 0;
    end
    if (redir) begin
      next_tag = (inst_valid && inst_ready) ? "R6" : (tgt[0] ? "R7" : "R5");
      exp_pc   = {tgt[31:1], 1'b0};
    end
    if (mem_req_valid && mem_req_ready) begin  // R9
      check(mem_req_addr[1:0] == 2'b00 && !mem_busy, "R9",
            {32'h0, mem_busy, mem_req_addr}, {33'h0, mem_req_addr & ~32'h3});
      mem_busy = 1;
      mem_lat  = $urandom % 3;
      mem_addr = mem_req_addr;
    end
    if (idle > 400) begin
      hung = 1;
      check(0, "R3 watchdog", 65'(idle), 65'd0);
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: quiet output and first read at the reset vector
    check(!inst_valid, "R1", 65'(inst_valid), 65'd0);
    check(mem_req_valid && mem_req_addr == RV, "R1",
          {32'h0, mem_req_valid, mem_req_addr}, {32'h0, 1'b1, RV});
    @(negedge clk);
    // directed: redirect while the first read is in flight (R5)
    step(1'b0, '0, 1 << 30);
    step(1'b1, RV + 32'h0000_0200, 1);
    // directed: odd target with bit 1 set, likely split (R7, R4)
    repeat (30) step(1'b0, '0, 1 << 30);
    step(1'b1, RV + 32'h0000_0103, 1);
    repeat (60) step(1'b0, '0, 1 << 30);
    // random, sparse redirects
    for (int c = 0; c < 8000 && !hung; c++) step(1'b0, '0, 40);
    // random, dense redirects: collisions with advances (R6)
    for (int c = 0; c < 4000 && !hung; c++) step(1'b0, '0, 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_cmp++;
    n_bad++;
    $display("FAIL R3 watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule